// File: doc/BRIEF.md
# JPEG Marker and Header Parser

This block is the front end of a baseline JPEG decoder. It takes the compressed file as a stream of 32-bit words and splits each word into bytes, lowest byte first. It then walks the marker segments of the file. Quantization-table and Huffman-table entries leave the block through two simple write ports. The frame width and height are taken from the baseline frame header, and the component sampling factors there are checked. Once the scan header has been read, the block raises a one-cycle scan-start pulse. From then on it forwards the entropy-coded bytes with stuffed zeros removed, until the end-of-image marker.

A one-cycle start pulse begins a parse. The pulse is only accepted while the idle output is high. Only a small set of markers is interpreted. Any other segment, including application data, is skipped using its own length field. Restart intervals, restart markers and any chroma layout other than 4:2:0 raise a sticky error flag, and the block returns to idle.

Top module: `jpeg_hdr_parse`

## Requirements
- R1: Each accepted 32-bit input word yields four bytes, in the order bits [7:0], [15:8], [23:16], [31:24]. No byte of one image is lost, duplicated or reordered.
- R2: `in_ack_o` is high for exactly one cycle per consumed word. It is only high while `in_vld_i` is high and a parse is under way.
- R3: `idle_o` is high out of reset and whenever no image is being parsed. A start pulse has no effect while `idle_o` is low. A stream that does not open with 0xFF 0xD8 raises `err_o`.
- R4: A quantization segment (marker 0xDB) may hold several tables. Each table starts with a header byte: bits [1:0] give the table id, and bits [7:4] must be zero, otherwise `err_o` is raised. The 64 bytes that follow are written in stream order with index 0 to 63.
- R5: A Huffman segment (marker 0xC4) starts each table with a header byte: bit 4 is the class and bits [1:0] the id. A class field (bits [7:4]) above 1 is an error. The 16 count bytes are written with `ht_sym_o`=0 and index 0 to 15. Then the symbol bytes are written with `ht_sym_o`=1 and index 0 to sum-of-counts minus 1.
- R6: In a baseline frame header (marker 0xC0), payload bytes 1 and 2 give the height and bytes 3 and 4 give the width, both big-endian. They appear on `img_h_o` and `img_w_o` and hold until the next frame header.
- R7: The frame header must give precision 8 and three components. The first component must have sampling byte 0x22 and the other two 0x11. Otherwise `err_o` is raised and the block goes idle.
- R8: A restart-interval marker (0xDD), or a restart marker (0xD0 to 0xD7), raises `err_o` and returns the block to idle, whether it is met between segments or inside the scan.
- R9: Any marker outside the interpreted set (0xD8, 0xD9, 0xDB, 0xC4, 0xC0, 0xDA, 0xDD, 0xD0 to 0xD7) is skipped using its big-endian length field, which counts itself. Extra 0xFF fill bytes before a marker code are ignored.
- R10: After the last payload byte of the scan header (marker 0xDA), `scan_start_o` pulses once. Each scan byte other than 0xFF is forwarded on `scan_byte_o` with `scan_vld_o`. The pair 0xFF 0x00 is forwarded as a single 0xFF.
- R11: The pair 0xFF 0xD9 ends the image: `idle_o` rises and `err_o` stays low. While idle, no table write or scan byte is issued.
- R12: `err_o` stays high after an error until the next accepted start pulse clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle pulse that begins a parse |
| in_word_i | input | 32 | Input word, four bytes, little-endian |
| in_vld_i | input | 1 | Input word valid |
| in_ack_o | output | 1 | Word consumed this cycle |
| idle_o | output | 1 | No parse in progress |
| err_o | output | 1 | Sticky error flag |
| img_w_o | output | 16 | Frame width |
| img_h_o | output | 16 | Frame height |
| qt_we_o | output | 1 | Quantization table write strobe |
| qt_id_o | output | 2 | Quantization table id |
| qt_idx_o | output | 6 | Coefficient index, stream order |
| qt_val_o | output | 8 | Coefficient value |
| ht_we_o | output | 1 | Huffman table write strobe |
| ht_cls_o | output | 1 | Huffman class (0 DC, 1 AC) |
| ht_id_o | output | 2 | Huffman table id |
| ht_sym_o | output | 1 | 0 count entry, 1 symbol entry |
| ht_idx_o | output | 12 | Entry index |
| ht_val_o | output | 8 | Entry value |
| scan_start_o | output | 1 | One-cycle pulse when scan data begins |
| scan_vld_o | output | 1 | Scan byte valid |
| scan_byte_o | output | 8 | De-stuffed scan byte |

## Verification
Two events can fall in the same cycle. One is the refill of the word register, which raises `in_ack_o`. The other is the consumption of the last byte of the previous word by the segment walker. The bench provokes this by holding `in_vld_i` high without a gap for one whole image, then mixes in random gaps for the later images. It judges the result by comparing every table write, the frame size and every de-stuffed scan byte against lists it builds while composing the file, so a byte dropped or repeated at the refill boundary shows up as a mismatch.

// File: rtl/jhp_pkg.sv
package jhp_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_SOI0, ST_SOI1, ST_MK0, ST_MK1,
    ST_LEN0, ST_LEN1, ST_BODY, ST_SCAN, ST_SCANFF
  } ctl_st_e;

  typedef enum logic [2:0] {
    SEG_SKIP, SEG_QTAB, SEG_HTAB, SEG_FRAME, SEG_SCANHDR
  } seg_e;

  localparam logic [7:0] LUMA_HV   = 8'h22;
  localparam logic [7:0] CHROMA_HV = 8'h11;

  // Map a marker code to the kind of segment handling it needs
  function automatic seg_e classify(input logic [7:0] code);
    seg_e k;
    case (code)
      8'hDB:   k = SEG_QTAB;
      8'hC4:   k = SEG_HTAB;
      8'hC0:   k = SEG_FRAME;
      8'hDA:   k = SEG_SCANHDR;
      default: k = SEG_SKIP;
    endcase
    return k;
  endfunction

  function automatic logic is_restart(input logic [7:0] code);
    return (code & 8'hF8) == 8'hD0;
  endfunction

  function automatic logic sampling_ok(input logic [1:0] comp, input logic [7:0] hv);
    return (comp == 2'd0) ? (hv == LUMA_HV) : (hv == CHROMA_HV);
  endfunction

endpackage

// File: rtl/jhp_unpack.sv
module jhp_unpack #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active_i,
  input  logic [WORD_W-1:0] in_word_i,
  input  logic              in_vld_i,
  output logic              in_ack_o,
  output logic              byte_vld_o,
  output logic [7:0]        byte_o
);
  localparam int BPW   = WORD_W / 8;
  localparam int PTR_W = $clog2(BPW);

  logic [WORD_W-1:0] word_q;
  logic [PTR_W-1:0]  ptr_q;
  logic              have_q;
  logic              last_byte;

  assign last_byte  = (ptr_q == PTR_W'(BPW - 1));
  // refill when empty, or in the same cycle the last held byte is taken
  assign in_ack_o   = active_i && in_vld_i && (!have_q || last_byte);
  assign byte_vld_o = have_q && active_i;
  assign byte_o     = word_q[{ptr_q, 3'b000} +: 8];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      ptr_q  <= '0;
      have_q <= 1'b0;
    end else if (!active_i) begin
      have_q <= 1'b0;
      ptr_q  <= '0;
    end else if (in_ack_o) begin
      word_q <= in_word_i;
      ptr_q  <= '0;
      have_q <= 1'b1;
    end else if (have_q) begin
      ptr_q <= ptr_q + 1'b1;
      if (last_byte) have_q <= 1'b0;
    end
  end

  AST_ACK_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    in_ack_o |-> (in_vld_i && active_i)); // R2

endmodule

// File: rtl/jhp_ctrl.sv
module jhp_ctrl
  import jhp_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic        byte_vld_i,
  input  logic [7:0]  byte_i,
  input  logic        tab_fault_i,
  output logic        idle_o,
  output logic        err_o,
  output logic        body_vld_o,
  output seg_e        body_kind_o,
  output logic [15:0] body_pos_o,
  output logic        scan_start_o,
  output logic        scan_vld_o,
  output logic [7:0]  scan_byte_o
);
  ctl_st_e     st_q;
  seg_e        kind_q;
  logic [7:0]  len_hi_q;
  logic [15:0] rem_q, pos_q;
  logic        err_q, ss_q, sv_q;
  logic [7:0]  sb_q;
  logic [15:0] seg_len;

  assign seg_len      = {len_hi_q, byte_i};
  assign idle_o       = (st_q == ST_IDLE);
  assign err_o        = err_q;
  assign body_vld_o   = byte_vld_i && (st_q == ST_BODY);
  assign body_kind_o  = kind_q;
  assign body_pos_o   = pos_q;
  assign scan_start_o = ss_q;
  assign scan_vld_o   = sv_q;
  assign scan_byte_o  = sb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      kind_q   <= SEG_SKIP;
      len_hi_q <= '0;
      rem_q    <= '0;
      pos_q    <= '0;
      err_q    <= 1'b0;
      ss_q     <= 1'b0;
      sv_q     <= 1'b0;
      sb_q     <= '0;
    end else begin
      ss_q <= 1'b0;
      sv_q <= 1'b0;
      if (st_q == ST_IDLE) begin
        if (start_i) begin
          st_q  <= ST_SOI0;
          err_q <= 1'b0;
        end
      end else if (byte_vld_i) begin
        case (st_q)
          ST_SOI0: if (byte_i == 8'hFF) st_q <= ST_SOI1;
                   else begin st_q <= ST_IDLE; err_q <= 1'b1; end
          ST_SOI1: if (byte_i == 8'hD8) st_q <= ST_MK0;
                   else begin st_q <= ST_IDLE; err_q <= 1'b1; end
          ST_MK0:  if (byte_i == 8'hFF) st_q <= ST_MK1;
                   else begin st_q <= ST_IDLE; err_q <= 1'b1; end
          ST_MK1: begin
            if (byte_i == 8'hFF) begin
              st_q <= ST_MK1;
            end else if (byte_i == 8'hD9) begin
              st_q <= ST_IDLE;
            end else if (byte_i == 8'hDD || byte_i == 8'hD8 || is_restart(byte_i)) begin
              st_q  <= ST_IDLE;
              err_q <= 1'b1;
            end else begin
              kind_q <= classify(byte_i);
              st_q   <= ST_LEN0;
            end
          end
          ST_LEN0: begin
            len_hi_q <= byte_i;
            st_q     <= ST_LEN1;
          end
          ST_LEN1: begin
            if (seg_len < 16'd2) begin
              st_q  <= ST_IDLE;
              err_q <= 1'b1;
            end else if (seg_len == 16'd2) begin
              if (kind_q == SEG_SCANHDR) begin
                st_q <= ST_SCAN;
                ss_q <= 1'b1;
              end else begin
                st_q <= ST_MK0;
              end
            end else begin
              rem_q <= seg_len - 16'd2;
              pos_q <= '0;
              st_q  <= ST_BODY;
            end
          end
          ST_BODY: begin
            if (tab_fault_i) begin
              st_q  <= ST_IDLE;
              err_q <= 1'b1;
            end else begin
              pos_q <= pos_q + 16'd1;
              rem_q <= rem_q - 16'd1;
              if (rem_q == 16'd1) begin
                if (kind_q == SEG_SCANHDR) begin
                  st_q <= ST_SCAN;
                  ss_q <= 1'b1;
                end else begin
                  st_q <= ST_MK0;
                end
              end
            end
          end
          ST_SCAN: begin
            if (byte_i == 8'hFF) begin
              st_q <= ST_SCANFF;
            end else begin
              sv_q <= 1'b1;
              sb_q <= byte_i;
            end
          end
          ST_SCANFF: begin
            if (byte_i == 8'h00) begin
              sv_q <= 1'b1;
              sb_q <= 8'hFF;
              st_q <= ST_SCAN;
            end else if (byte_i == 8'hD9) begin
              st_q <= ST_IDLE;
            end else if (byte_i != 8'hFF) begin
              st_q  <= ST_IDLE;
              err_q <= 1'b1;
            end
          end
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end

  AST_ERR_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_o) |-> idle_o); // R8

  AST_SCAN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    scan_start_o |=> !scan_start_o); // R10

  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle_o && start_i && !byte_vld_i) |=> $stable(st_q)); // R3

endmodule

// File: rtl/jhp_tables.sv
module jhp_tables
  import jhp_pkg::*;
#(
  parameter int HIDX_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              body_vld_i,
  input  logic [7:0]        body_byte_i,
  input  seg_e              body_kind_i,
  input  logic [15:0]       body_pos_i,
  output logic              fault_o,
  output logic              dim_load_o,
  output logic [15:0]       img_w_o,
  output logic [15:0]       img_h_o,
  output logic              qt_we_o,
  output logic [1:0]        qt_id_o,
  output logic [5:0]        qt_idx_o,
  output logic [7:0]        qt_val_o,
  output logic              ht_we_o,
  output logic              ht_cls_o,
  output logic [1:0]        ht_id_o,
  output logic              ht_sym_o,
  output logic [HIDX_W-1:0] ht_idx_o,
  output logic [7:0]        ht_val_o
);
  typedef enum logic [1:0] {HP_HDR, HP_CNT, HP_SYM} hph_e;

  logic              q_hdr_q;
  logic [1:0]        q_id_q;
  logic [5:0]        q_cnt_q;
  hph_e              h_ph_q;
  logic              h_cls_q;
  logic [1:0]        h_id_q;
  logic [HIDX_W-1:0] h_cnt_q, h_sum_q, h_sum_nx;
  logic [7:0]        dim_hi_q;

  logic seg_first, is_q, is_h, is_f, q_hdr_now, h_hdr_now, frame_bad;

  assign seg_first = (body_pos_i == 16'd0);
  assign is_q      = body_vld_i && (body_kind_i == SEG_QTAB);
  assign is_h      = body_vld_i && (body_kind_i == SEG_HTAB);
  assign is_f      = body_vld_i && (body_kind_i == SEG_FRAME);
  assign q_hdr_now = seg_first || q_hdr_q;
  assign h_hdr_now = seg_first || (h_ph_q == HP_HDR);
  assign h_sum_nx  = h_sum_q + {{(HIDX_W-8){1'b0}}, body_byte_i};

  always_comb begin
    frame_bad = 1'b0;
    case (body_pos_i)
      16'd0:   frame_bad = (body_byte_i != 8'd8);
      16'd5:   frame_bad = (body_byte_i != 8'd3);
      16'd7:   frame_bad = !sampling_ok(2'd0, body_byte_i);
      16'd10:  frame_bad = !sampling_ok(2'd1, body_byte_i);
      16'd13:  frame_bad = !sampling_ok(2'd2, body_byte_i);
      default: frame_bad = 1'b0;
    endcase
  end

  assign fault_o = (is_q && q_hdr_now && (body_byte_i[7:4] != 4'd0)) ||
                   (is_h && h_hdr_now && (body_byte_i[7:4] > 4'd1)) ||
                   (is_f && frame_bad);
  assign dim_load_o = is_f && (body_pos_i == 16'd2 || body_pos_i == 16'd4);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_hdr_q  <= 1'b1;
      q_id_q   <= '0;
      q_cnt_q  <= '0;
      h_ph_q   <= HP_HDR;
      h_cls_q  <= 1'b0;
      h_id_q   <= '0;
      h_cnt_q  <= '0;
      h_sum_q  <= '0;
      dim_hi_q <= '0;
      img_w_o  <= '0;
      img_h_o  <= '0;
      qt_we_o  <= 1'b0;
      qt_id_o  <= '0;
      qt_idx_o <= '0;
      qt_val_o <= '0;
      ht_we_o  <= 1'b0;
      ht_cls_o <= 1'b0;
      ht_id_o  <= '0;
      ht_sym_o <= 1'b0;
      ht_idx_o <= '0;
      ht_val_o <= '0;
    end else begin
      qt_we_o <= 1'b0;
      ht_we_o <= 1'b0;
      if (is_q && !fault_o) begin
        if (q_hdr_now) begin
          q_id_q  <= body_byte_i[1:0];
          q_cnt_q <= '0;
          q_hdr_q <= 1'b0;
        end else begin
          qt_we_o  <= 1'b1;
          qt_id_o  <= q_id_q;
          qt_idx_o <= q_cnt_q;
          qt_val_o <= body_byte_i;
          q_cnt_q  <= q_cnt_q + 6'd1;
          if (q_cnt_q == 6'd63) q_hdr_q <= 1'b1;
        end
      end
      if (is_h && !fault_o) begin
        if (h_hdr_now) begin
          h_cls_q <= body_byte_i[4];
          h_id_q  <= body_byte_i[1:0];
          h_ph_q  <= HP_CNT;
          h_cnt_q <= '0;
          h_sum_q <= '0;
        end else begin
          ht_we_o  <= 1'b1;
          ht_cls_o <= h_cls_q;
          ht_id_o  <= h_id_q;
          ht_idx_o <= h_cnt_q;
          ht_val_o <= body_byte_i;
          if (h_ph_q == HP_CNT) begin
            ht_sym_o <= 1'b0;
            h_sum_q  <= h_sum_nx;
            if (h_cnt_q == HIDX_W'(15)) begin
              h_cnt_q <= '0;
              h_ph_q  <= (h_sum_nx == '0) ? HP_HDR : HP_SYM;
            end else begin
              h_cnt_q <= h_cnt_q + 1'b1;
            end
          end else begin
            ht_sym_o <= 1'b1;
            h_cnt_q  <= h_cnt_q + 1'b1;
            if (h_cnt_q + 1'b1 == h_sum_q) h_ph_q <= HP_HDR;
          end
        end
      end
      if (is_f && !fault_o) begin
        if (body_pos_i == 16'd1 || body_pos_i == 16'd3) dim_hi_q <= body_byte_i;
        if (body_pos_i == 16'd2) img_h_o <= {dim_hi_q, body_byte_i};
        if (body_pos_i == 16'd4) img_w_o <= {dim_hi_q, body_byte_i};
      end
    end
  end

  AST_DIM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !dim_load_o |=> ($stable(img_w_o) && $stable(img_h_o))); // R6

  AST_HT_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (ht_we_o && !ht_sym_o) |-> (ht_idx_o < HIDX_W'(16))); // R5

  AST_FAULT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |=> !(qt_we_o || ht_we_o)); // R4

endmodule

// File: rtl/jpeg_hdr_parse.sv
module jpeg_hdr_parse
  import jhp_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int HIDX_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [WORD_W-1:0] in_word_i,
  input  logic              in_vld_i,
  output logic              in_ack_o,
  output logic              idle_o,
  output logic              err_o,
  output logic [15:0]       img_w_o,
  output logic [15:0]       img_h_o,
  output logic              qt_we_o,
  output logic [1:0]        qt_id_o,
  output logic [5:0]        qt_idx_o,
  output logic [7:0]        qt_val_o,
  output logic              ht_we_o,
  output logic              ht_cls_o,
  output logic [1:0]        ht_id_o,
  output logic              ht_sym_o,
  output logic [HIDX_W-1:0] ht_idx_o,
  output logic [7:0]        ht_val_o,
  output logic              scan_start_o,
  output logic              scan_vld_o,
  output logic [7:0]        scan_byte_o
);
  logic        byte_vld, body_vld, tab_fault, dim_load;
  logic [7:0]  byte_w;
  seg_e        body_kind;
  logic [15:0] body_pos;

  jhp_unpack #(.WORD_W(WORD_W)) u_unpack (
    .clk(clk), .rst_n(rst_n), .active_i(!idle_o),
    .in_word_i(in_word_i), .in_vld_i(in_vld_i), .in_ack_o(in_ack_o),
    .byte_vld_o(byte_vld), .byte_o(byte_w)
  );

  jhp_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .byte_vld_i(byte_vld), .byte_i(byte_w), .tab_fault_i(tab_fault),
    .idle_o(idle_o), .err_o(err_o),
    .body_vld_o(body_vld), .body_kind_o(body_kind), .body_pos_o(body_pos),
    .scan_start_o(scan_start_o), .scan_vld_o(scan_vld_o), .scan_byte_o(scan_byte_o)
  );

  jhp_tables #(.HIDX_W(HIDX_W)) u_tables (
    .clk(clk), .rst_n(rst_n),
    .body_vld_i(body_vld), .body_byte_i(byte_w),
    .body_kind_i(body_kind), .body_pos_i(body_pos),
    .fault_o(tab_fault), .dim_load_o(dim_load),
    .img_w_o(img_w_o), .img_h_o(img_h_o),
    .qt_we_o(qt_we_o), .qt_id_o(qt_id_o), .qt_idx_o(qt_idx_o), .qt_val_o(qt_val_o),
    .ht_we_o(ht_we_o), .ht_cls_o(ht_cls_o), .ht_id_o(ht_id_o), .ht_sym_o(ht_sym_o),
    .ht_idx_o(ht_idx_o), .ht_val_o(ht_val_o)
  );

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    idle_o |-> !(qt_we_o || ht_we_o || scan_vld_o)); // R11

  AST_FRAME_LOAD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    dim_load |-> !idle_o); // R6

endmodule

// File: tb/tb_jpeg_hdr_parse.sv
`timescale 1ns/1ps
module tb_jpeg_hdr_parse;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] in_word_i = '0;
  logic        in_vld_i = 1'b0;
  logic        in_ack_o, idle_o, err_o;
  logic [15:0] img_w_o, img_h_o;
  logic        qt_we_o, ht_we_o, ht_cls_o, ht_sym_o, scan_start_o, scan_vld_o;
  logic [1:0]  qt_id_o, ht_id_o;
  logic [5:0]  qt_idx_o;
  logic [7:0]  qt_val_o, ht_val_o, scan_byte_o;
  logic [11:0] ht_idx_o;

  always #2.5 clk = ~clk;

  jpeg_hdr_parse dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .in_word_i(in_word_i),
    .in_vld_i(in_vld_i), .in_ack_o(in_ack_o), .idle_o(idle_o), .err_o(err_o),
    .img_w_o(img_w_o), .img_h_o(img_h_o),
    .qt_we_o(qt_we_o), .qt_id_o(qt_id_o), .qt_idx_o(qt_idx_o), .qt_val_o(qt_val_o),
    .ht_we_o(ht_we_o), .ht_cls_o(ht_cls_o), .ht_id_o(ht_id_o), .ht_sym_o(ht_sym_o),
    .ht_idx_o(ht_idx_o), .ht_val_o(ht_val_o),
    .scan_start_o(scan_start_o), .scan_vld_o(scan_vld_o), .scan_byte_o(scan_byte_o)
  );

  int nchk = 0, nerr = 0;
  bit done = 0;

  logic [7:0]  sb [0:1023];
  int          sn;
  logic [15:0] eq [0:255];
  logic [23:0] eh [0:255];
  logic [7:0]  es [0:255];
  int          neq, neh, nes;
  logic [15:0] cq [0:255];
  logic [23:0] ch [0:255];
  logic [7:0]  cs [0:255];
  int          ncq, nch, ncs, nss;
  int          exp_w = 0, exp_h = 0;
  int          nwords, nacked, bad_ack;

  function automatic logic [15:0] qkey(int id, int idx, int v);
    return {id[1:0], idx[5:0], v[7:0]};
  endfunction

  function automatic logic [23:0] hkey(int cls, int id, int sym, int idx, int v);
    return {cls[0], id[1:0], sym[0], idx[11:0], v[7:0]};
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (qt_we_o) begin
      if (ncq < 256) cq[ncq] = {qt_id_o, qt_idx_o, qt_val_o};
      ncq++;
    end
    if (ht_we_o) begin
      if (nch < 256) ch[nch] = {ht_cls_o, ht_id_o, ht_sym_o, ht_idx_o, ht_val_o};
      nch++;
    end
    if (scan_vld_o) begin
      if (ncs < 256) cs[ncs] = scan_byte_o;
      ncs++;
    end
    if (scan_start_o) nss++;
  end

  task automatic put(input int b);
    sb[sn] = b[7:0];
    sn++;
  endtask

  // mode 0 good, 1 restart interval, 2 bad sampling, 3 restart in scan, 4 bad start of image
  task automatic build(input int mode);
    int napp, sum, len, id0, cls, hid, n;
    int cnt [16];
    sn = 0; neq = 0; neh = 0; nes = 0;
    if (mode == 4) begin put(8'hFF); put(8'h00); end
    else begin put(8'hFF); put(8'hD8); end
    napp = 1 + int'($urandom % 8);
    put(8'hFF); put(8'hFF); put(8'hE1); put(0); put(2 + napp);
    for (int k = 0; k < napp; k++) put(int'($urandom % 256));
    if (mode == 1) begin put(8'hFF); put(8'hDD); put(0); put(4); put(0); put(16); end
    put(8'hFF); put(8'hDB); put(0); put(132);
    id0 = int'($urandom % 4);
    for (int t = 0; t < 2; t++) begin
      put((id0 + t) % 4);
      for (int k = 0; k < 64; k++) begin
        int v = int'($urandom % 256);
        put(v);
        eq[neq] = qkey((id0 + t) % 4, k, v); neq++;
      end
    end
    cls = int'($urandom % 2); hid = int'($urandom % 4); sum = 0;
    for (int k = 0; k < 16; k++) begin cnt[k] = int'($urandom % 3); sum += cnt[k]; end
    len = 19 + sum;
    put(8'hFF); put(8'hC4); put(len / 256); put(len % 256); put(cls * 16 + hid);
    for (int k = 0; k < 16; k++) begin put(cnt[k]); eh[neh] = hkey(cls, hid, 0, k, cnt[k]); neh++; end
    for (int k = 0; k < sum; k++) begin
      int v = int'($urandom % 256);
      put(v); eh[neh] = hkey(cls, hid, 1, k, v); neh++;
    end
    if (mode == 0 || mode == 2 || mode == 3) begin
      exp_h = int'($urandom % 65536); exp_w = int'($urandom % 65536);
    end
    put(8'hFF); put(8'hC0); put(0); put(17); put(8);
    put(exp_h / 256); put(exp_h % 256); put(exp_w / 256); put(exp_w % 256); put(3);
    put(1); put(mode == 2 ? 8'h21 : 8'h22); put(0);
    put(2); put(8'h11); put(1); put(3); put(8'h11); put(1);
    put(8'hFF); put(8'hDA); put(0); put(12);
    put(3); put(1); put(0); put(2); put(8'h11); put(3); put(8'h11); put(0); put(63); put(0);
    n = 20 + int'($urandom % 40);
    for (int k = 0; k < n; k++) begin
      if (mode == 3 && k == 10) begin put(8'hFF); put(8'hD3); end
      if ($urandom % 6 == 0) begin put(8'hFF); put(8'h00); es[nes] = 8'hFF; nes++; end
      else begin
        int b = int'($urandom % 255);
        put(b); es[nes] = b[7:0]; nes++;
      end
    end
    put(8'hFF); put(8'hD9);
  endtask

  task automatic send(input bit gaps);
    bit abort = 0;
    nwords = (sn + 3) / 4; nacked = 0;
    for (int i = 0; i < nwords && !abort; i++) begin
      bit got = 0;
      if (gaps && ($urandom % 3 == 0)) begin
        in_vld_i = 1'b0;
        repeat (1 + int'($urandom % 3)) begin
          #1; if (in_ack_o) bad_ack++;
          @(negedge clk);
        end
      end
      for (int j = 0; j < 4; j++)
        in_word_i[8*j +: 8] = (4*i + j < sn) ? sb[4*i + j] : 8'h00;
      in_vld_i = 1'b1;
      while (!got && !abort) begin
        #1;
        if (in_ack_o) begin got = 1; nacked++; end
        else if (idle_o) abort = 1;
        @(negedge clk);
      end
    end
    in_vld_i = 1'b0;
  endtask

  task automatic run_image(input int mode, input bit gaps, input bit poke);
    int t = 0;
    ncq = 0; nch = 0; ncs = 0; nss = 0; bad_ack = 0;
    build(mode);
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    check(err_o == 1'b0, "R12 err cleared by start", err_o, 0);
    fork
      send(gaps);
      begin
        if (poke) begin
          repeat (20) @(negedge clk);
          start_i = 1'b1; @(negedge clk); start_i = 1'b0;
        end
      end
    join
    while (!idle_o && t < 4000) begin @(negedge clk); t++; end
    repeat (3) @(negedge clk);
    check(idle_o == 1'b1, "R3 idle after image", idle_o, 1);
  endtask

  task automatic judge_good(input string tag);
    int bad;
    check(err_o == 1'b0, {tag, " R11 no error at end of image"}, err_o, 0);
    check(ncq == neq, {tag, " R4 R9 quant write count"}, ncq, neq);
    bad = 0;
    for (int k = 0; k < neq && k < ncq; k++) if (cq[k] !== eq[k]) bad++;
    check(bad == 0, {tag, " R4 quant entries"}, bad, 0);
    check(nch == neh, {tag, " R5 huffman write count"}, nch, neh);
    bad = 0;
    for (int k = 0; k < neh && k < nch; k++) if (ch[k] !== eh[k]) bad++;
    check(bad == 0, {tag, " R5 huffman entries"}, bad, 0);
    check(nss == 1, {tag, " R10 scan start pulses"}, nss, 1);
    check(ncs == nes, {tag, " R10 scan byte count"}, ncs, nes);
    bad = 0;
    for (int k = 0; k < nes && k < ncs; k++) if (cs[k] !== es[k]) bad++;
    check(bad == 0, {tag, " R1 R10 scan bytes"}, bad, 0);
    check(int'(img_w_o) == exp_w, {tag, " R6 width"}, int'(img_w_o), exp_w);
    check(int'(img_h_o) == exp_h, {tag, " R6 height"}, int'(img_h_o), exp_h);
    check(nacked == nwords && bad_ack == 0, {tag, " R2 acks"}, nacked, nwords);
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(idle_o == 1'b1, "R3 reset idle", idle_o, 1);
    check(err_o == 1'b0, "R12 reset err", err_o, 0);
    check(in_ack_o == 1'b0 && scan_vld_o == 1'b0, "R2 R11 reset outputs", in_ack_o, 0);

    run_image(0, 1'b0, 1'b0); judge_good("back-to-back words");
    run_image(0, 1'b1, 1'b1); judge_good("gaps with start while busy R3");

    run_image(1, 1'b1, 1'b0);
    check(err_o == 1'b1, "R8 restart interval error", err_o, 1);
    check(ncq == 0, "R8 no table writes after restart interval", ncq, 0);
    check(int'(img_w_o) == exp_w, "R6 width held across image", int'(img_w_o), exp_w);
    repeat (10) @(negedge clk);
    check(err_o == 1'b1, "R12 error stays set", err_o, 1);

    run_image(0, 1'b1, 1'b0); judge_good("after error");

    run_image(2, 1'b1, 1'b0);
    check(err_o == 1'b1, "R7 bad sampling error", err_o, 1);
    check(nss == 0, "R7 no scan after bad frame", nss, 0);

    run_image(3, 1'b0, 1'b0);
    check(err_o == 1'b1, "R8 restart marker in scan", err_o, 1);
    check(nss == 1, "R10 scan had started", nss, 1);

    run_image(4, 1'b1, 1'b0);
    check(err_o == 1'b1, "R3 missing start of image", err_o, 1);

    for (int r = 0; r < 4; r++) begin
      run_image(0, 1'b1, 1'b0); judge_good("random image");
    end

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    #900000;
    if (!done) begin
      done = 1;
      nchk++; nerr++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end
endmodule